// File: doc/BRIEF.md
# RC4 Keystream Engine

This block produces an RC4 keystream, one byte per request, from a key of up to `KEY_MAX` bytes. Software-facing logic writes the key bytes one at a time into a small key store, sets the key length, and pulses `start`. The engine then runs its setup phase: it first fills the 256-entry permutation table with the identity, then scrambles it under the key. During setup `busy` is high; when setup ends, both indices are cleared and `ready` rises.

Each request accepted while `ready` is high walks the table through a fixed five-step sequence on a single-port memory: read at the advanced index, read at the accumulated index, two writes that swap the entries, and a read at the sum of the two values. The resulting byte appears on `ks_byte` with a one-cycle `out_valid` pulse. The byte presented on `din` with the request is XORed with it on `dout`, so the same path both encrypts and decrypts.

Top module: `rc4_stream_core`

## Requirements
- R1: After reset `ready`, `busy` and `out_valid` are all 0, and no request is accepted until a setup has completed.
- R2: A `start` pulse while not busy raises `busy` on the next cycle; `busy` stays high for exactly 1280 cycles (256 fill cycles plus 4 per scramble step) and `ready` rises as it falls; `busy` and `ready` are never high together.
- R3: The sequence of `ks_byte` values after a setup equals the RC4 keystream for the loaded key, with key byte 0 used first.
- R4: When `out_valid` is high, `dout` equals the `din` byte sampled with the request XOR `ks_byte`.
- R5: A request accepted at a clock edge (`req` and `ready` both high) lowers `ready` and produces `out_valid` high for exactly one cycle, visible 5 cycles after the accepting edge, when `ready` returns.
- R6: `req` has no effect while `ready` is low (before the first setup, during setup, during a byte sequence): no `out_valid` results and the keystream position does not advance.
- R7: A new `start` after keystream output restarts the keystream from its first byte for the loaded key.
- R8: During scrambling the key byte index wraps at `key_len`, for any length from 1 to `KEY_MAX`; `key_len` is sampled at `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr | input | 1 | Write `key_byte` into key slot `key_idx` (ignored while busy) |
| key_idx | input | $clog2(KEY_MAX) | Key slot to write |
| key_byte | input | 8 | Key byte value |
| key_len | input | $clog2(KEY_MAX+1) | Number of key bytes in use, 1..KEY_MAX |
| start | input | 1 | Begin setup with the stored key |
| busy | output | 1 | Setup in progress |
| ready | output | 1 | Engine can accept a keystream request |
| req | input | 1 | Request the next keystream byte |
| din | input | 8 | Data byte to combine, sampled with the request |
| out_valid | output | 1 | One-cycle pulse marking a new output byte |
| ks_byte | output | 8 | Keystream byte |
| dout | output | 8 | `din` XOR keystream byte |

## Verification
The properties assume `key_len` is between 1 and `KEY_MAX` when `start` is pulsed and that key slots are written only outside setup; the stimulus always loads keys and lengths before pulsing `start` and never writes the key store while `busy` is high. They also assume `start` is not raised in the middle of a byte sequence, which the bench respects by waiting for each `out_valid` before issuing anything new. Requests are deliberately held high while the engine is idle, busy, or before any key exists, so the latency and no-spurious-output properties are exercised against illegal request timing.

// File: rtl/rc4_stream_core.sv
module rc4_stream_core #(
  parameter int KEY_MAX = 16,
  localparam int KI_W = (KEY_MAX > 1) ? $clog2(KEY_MAX) : 1,
  localparam int KL_W = $clog2(KEY_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_wr,
  input  logic [KI_W-1:0] key_idx,
  input  logic [7:0]      key_byte,
  input  logic [KL_W-1:0] key_len,
  input  logic            start,
  output logic            busy,
  output logic            ready,
  input  logic            req,
  input  logic [7:0]      din,
  output logic            out_valid,
  output logic [7:0]      ks_byte,
  output logic [7:0]      dout
);

  typedef enum logic [3:0] {
    IDLE, FILL, K_RI, K_RJ, K_WI, K_WJ, RDY, P_RI, P_RJ, P_WI, P_WJ, P_RT
  } st_t;

  st_t             st;
  logic [7:0]      i, j, si, sj, din_q, ks_q;
  logic [KI_W-1:0] kp;
  logic [KL_W-1:0] len_q;
  logic            ov;

  logic [7:0] sbox [256];
  logic [7:0] kmem [KEY_MAX];

  logic [7:0] addr, wd, rd;
  logic       we;

  assign busy      = (st == FILL) || (st == K_RI) || (st == K_RJ) || (st == K_WI) || (st == K_WJ);
  assign ready     = (st == RDY);
  assign out_valid = ov;
  assign ks_byte   = ks_q;
  assign dout      = din_q ^ ks_q;

  always_comb begin
    addr = i;
    we   = 1'b0;
    wd   = i;
    case (st)
      FILL:       we = 1'b1;
      P_RI:       addr = i + 8'd1;
      K_RJ, P_RJ: addr = j;
      K_WI, P_WI: begin we = 1'b1; wd = sj; end
      K_WJ, P_WJ: begin addr = j; we = 1'b1; wd = si; end
      P_RT:       addr = si + sj;
      default:    ;
    endcase
  end

  assign rd = sbox[addr];

  always_ff @(posedge clk) begin
    if (we) sbox[addr] <= wd;
    if (key_wr && !busy) kmem[key_idx] <= key_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      i     <= '0;
      j     <= '0;
      si    <= '0;
      sj    <= '0;
      din_q <= '0;
      ks_q  <= '0;
      kp    <= '0;
      len_q <= '0;
      ov    <= 1'b0;
    end else begin
      ov <= 1'b0;
      case (st)
        IDLE, RDY: begin
          if (start) begin
            st    <= FILL;
            i     <= '0;
            j     <= '0;
            kp    <= '0;
            len_q <= key_len;
          end else if (st == RDY && req) begin
            st    <= P_RI;
            din_q <= din;
          end
        end
        FILL: begin
          i <= i + 8'd1;
          if (i == 8'd255) st <= K_RI;
        end
        K_RI: begin
          si <= rd;
          j  <= j + rd + kmem[kp];
          kp <= (KL_W'(kp) + KL_W'(1) >= len_q) ? '0 : kp + KI_W'(1);
          st <= K_RJ;
        end
        K_RJ: begin sj <= rd; st <= K_WI; end
        K_WI: st <= K_WJ;
        K_WJ: begin
          if (i == 8'd255) begin
            st <= RDY;
            i  <= '0;
            j  <= '0;
          end else begin
            i  <= i + 8'd1;
            st <= K_RI;
          end
        end
        P_RI: begin
          i  <= i + 8'd1;
          si <= rd;
          j  <= j + rd;
          st <= P_RJ;
        end
        P_RJ: begin sj <= rd; st <= P_WI; end
        P_WI: st <= P_WJ;
        P_WJ: st <= P_RT;
        P_RT: begin
          ks_q <= rd;
          ov   <= 1'b1;
          st   <= RDY;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rc4_stream_chk.sv
module rc4_stream_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       req,
  input logic       busy,
  input logic       ready,
  input logic       out_valid,
  input logic [7:0] din,
  input logic [7:0] ks_byte,
  input logic [7:0] dout
);
  localparam int SETUP = 1280;

  logic [7:0]  cap;
  logic [11:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
      cnt <= '0;
    end else begin
      if (req && ready) cap <= din;
      cnt <= busy ? cnt + 12'd1 : 12'd0;
    end
  end

  // R2
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && ready));
  // R2
  go_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R2
  setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (cnt == 12'(SETUP) && ready));
  // R5
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n) (req && ready && !start) |-> ##6 out_valid);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (req && ready && !start) |=> !ready);
  // R5
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
  // R6
  nospur_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(req && ready && !start, 6));
  // R4
  xor_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (dout == (cap ^ ks_byte)));
endmodule

bind rc4_stream_core rc4_stream_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .req(req), .busy(busy), .ready(ready),
  .out_valid(out_valid), .din(din), .ks_byte(ks_byte), .dout(dout)
);

// File: tb/rc4_stream_core_tb_top.sv
module rc4_stream_core_tb_top;
  localparam int CLK_T = 10;
  localparam int KMAX  = 16;
  localparam int NV    = 4;

  localparam logic [127:0] VKEY [NV] = '{
    {"Key", 104'h0}, {"Wiki", 96'h0}, {"Secret", 80'h0}, {40'h0102030405, 88'h0}};
  localparam int VKLEN [NV] = '{3, 4, 6, 5};
  localparam logic [127:0] VPT [NV] = '{
    {"Plaintext", 56'h0}, {"pedia", 88'h0}, {"Attack at dawn", 16'h0}, 128'h0};
  localparam int VPLEN [NV] = '{9, 5, 14, 16};
  localparam logic [127:0] VCT [NV] = '{
    {72'hBBF316E8D940AF0AD3, 56'h0}, {40'h1021BF0420, 88'h0},
    {112'h45A01F645FC35B383552544B9BF5, 16'h0}, 128'hB2396305F03DC027CCC3524A0A1118A8};

  logic       clk = 0, rst_n = 0;
  logic       key_wr = 0, start = 0, req = 0;
  logic [3:0] key_idx = 0;
  logic [7:0] key_byte = 0, din = 0;
  logic [4:0] key_len = 0;
  logic       busy, ready, out_valid;
  logic [7:0] ks_byte, dout;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] ms [256];
  int mi, mj;

  always #(CLK_T/2) clk = ~clk;

  rc4_stream_core #(.KEY_MAX(KMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_idx(key_idx), .key_byte(key_byte),
    .key_len(key_len), .start(start), .busy(busy), .ready(ready), .req(req), .din(din),
    .out_valid(out_valid), .ks_byte(ks_byte), .dout(dout));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] kb(input logic [127:0] v, input int b);
    return v[127-8*b -: 8];
  endfunction

  task automatic m_key(input logic [127:0] k, input int len);
    for (int n = 0; n < 256; n++) ms[n] = 8'(n);
    mj = 0;
    for (int n = 0; n < 256; n++) begin
      logic [7:0] t;
      mj = (mj + ms[n] + kb(k, n % len)) % 256;
      t = ms[n]; ms[n] = ms[mj]; ms[mj] = t;
    end
    mi = 0; mj = 0;
  endtask

  function automatic logic [7:0] m_next();
    logic [7:0] t;
    mi = (mi + 1) % 256;
    mj = (mj + ms[mi]) % 256;
    t = ms[mi]; ms[mi] = ms[mj]; ms[mj] = t;
    return ms[8'(ms[mi] + ms[mj])];
  endfunction

  task automatic load_key(input logic [127:0] k, input int len, input bit noise);
    int n;
    bit spur;
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      key_wr = 1; key_idx = 4'(b); key_byte = kb(k, b);
    end
    @(negedge clk);
    key_wr = 0; key_len = 5'(len); start = 1;
    @(negedge clk);
    start = 0;
    req = noise;
    n = 0; spur = 0;
    while (busy && n < 3000) begin
      n++;
      if (out_valid) spur = 1;
      @(negedge clk);
    end
    req = 0;
    // R2 setup length and handover
    check(n == 1280, "R2 setup cycles", n, 1280);
    check(ready == 1'b1, "R2 ready after setup", ready, 1);
    if (noise) check(!spur && !out_valid, "R6 req during setup", spur, 0);
  endtask

  task automatic get_byte(input logic [7:0] d, output logic [7:0] ks, output logic [7:0] o, output int lat);
    req = 1; din = d;
    @(negedge clk);
    req = 0; din = 8'hA5;
    lat = 0;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    ks = ks_byte; o = dout;
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ks, o, e;
    int lat;
    bit spur;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready == 0 && busy == 0 && out_valid == 0, "R1 reset outputs", {ready, busy, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    req = 1; spur = 0;
    repeat (12) begin
      @(negedge clk);
      if (out_valid || ready) spur = 1;
    end
    req = 0;
    // R1 R6 no request before setup
    check(!spur, "R1 R6 req before key", spur, 0);

    for (int v = 0; v < NV; v++) begin
      load_key(VKEY[v], VKLEN[v], v == 1);
      m_key(VKEY[v], VKLEN[v]);
      for (int b = 0; b < VPLEN[v]; b++) begin
        e = m_next();
        get_byte(kb(VPT[v], b), ks, o, lat);
        check(ks == e, "R3 keystream vs model", ks, e);
        check(o == kb(VCT[v], b), "R3 R4 ciphertext vs vector", o, kb(VCT[v], b));
        check((kb(VPT[v], b) ^ e) == kb(VCT[v], b), "R3 model vs vector", kb(VPT[v], b) ^ e, kb(VCT[v], b));
        check(lat == 5, "R5 latency", lat, 5);
        @(negedge clk);
        check(!out_valid && ready, "R5 single pulse", {out_valid, ready}, 1);
      end
    end

    // R7 restart with the last key gives the first byte again
    load_key(VKEY[3], 5, 0);
    get_byte(8'h00, ks, o, lat);
    check(ks == 8'hB2, "R7 restart", ks, 8'hB2);
    get_byte(8'hFF, ks, o, lat);
    check(ks == 8'h39 && o == 8'hC6, "R7 R4 second byte", {ks, o}, 16'h39C6);

    // R8 shortest and longest keys
    for (int c = 0; c < 2; c++) begin
      logic [127:0] k;
      int len;
      k = (c == 0) ? {8'h5C, 120'h0} : 128'hF00D_1234_9A8B_C7D6_0011_2233_FEDC_BA98;
      len = (c == 0) ? 1 : KMAX;
      load_key(k, len, 0);
      m_key(k, len);
      for (int b = 0; b < 40; b++) begin
        e = m_next();
        get_byte(8'(b * 7), ks, o, lat);
        check(ks == e, "R8 key wrap keystream", ks, e);
        check(o == (8'(b * 7) ^ e), "R4 xor", o, 8'(b * 7) ^ e);
      end
    end

    // R6 request held during a byte sequence does not advance the stream
    load_key(VKEY[0], 3, 0);
    m_key(VKEY[0], 3);
    req = 1; din = 8'h00;
    @(negedge clk);
    spur = 0;
    repeat (4) begin
      @(negedge clk);
      if (out_valid) spur = 1;
    end
    req = 0;
    @(negedge clk);
    e = m_next();
    check(out_valid && !spur && ks_byte == e, "R6 held req single byte", ks_byte, e);
    @(negedge clk);
    e = m_next();
    get_byte(8'h00, ks, o, lat);
    check(ks == e, "R6 stream position", ks, e);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule